// File: doc/BRIEF.md
# Port Credit Pool Manager

This block keeps the event-storage credit accounts for a small set of enqueue ports. There are two shared pools, one for load-balanced traffic and one for directed traffic, and every port holds a local balance in each. A port spends one credit of the matching kind to enqueue an event. If that balance is zero, the request is refused in the same cycle and is not held. Credits come back to the pools when events are released or scheduled. Ports whose balance has sunk to their low watermark are topped up from the pool one quantum at a time.

All pool sizes and watermarks are derived from three parameters: the number of ports, the configured event limit and the per-port enqueue depth. The load-balanced pool holds the full event limit. The directed pool holds a quarter of it, unless an override parameter gives a non-zero size. A start pulse arms the block and pre-charges each port with its high watermark from each pool. With the defaults (4 ports, limit 256, depth 32) the values are:

- Load-balanced: pool 256, high watermark 32, quantum 16, low watermark 16.
- Directed: pool 64, high watermark 16, quantum 8, low watermark 8.

Top module: `credit_pool_mgr`

## Requirements
- R1: After reset, the load-balanced pool reads EVENT_LIMIT and the directed pool reads EVENT_LIMIT/4 (256 and 64 by default). Every port balance reads 0, and every enqueue request is refused until the block has been started.
- R2: The first start pulse moves each port's high watermark into that port's balance for both pools. The next cycle reads pools of 128 and 0 by default, with port balances of 32 (load-balanced) and 16 (directed).
- R3: The load-balanced high watermark equals the enqueue depth. The directed high watermark is the smaller of the enqueue depth and the directed pool size divided by the port count. The quantum is half the high watermark, and the low watermark is the smaller of 16 and the quantum.
- R4: An accepted request with enq_dir_i low (0 = load-balanced, 1 = directed) takes one credit from that port's load-balanced balance. With enq_dir_i high it takes one credit from the directed balance. The new balance is visible the next cycle.
- R5: The accept (enq_ok_o) and refuse (enq_fail_o) bits for a port are combinational on the request. Exactly one of them is high while the request is high, and neither is high otherwise. A request is refused when the balance of its kind is zero, and a refused request changes no count.
- R6: When a port's balance is at or below its low watermark and the pool holds at least one quantum, one quantum moves from the pool to the port at the next clock edge.
- R7: Each pool refills at most one port per cycle. The ports are chosen round-robin, starting from the port after the one last served, and port 0 is served first after reset.
- R8: A port balance never exceeds its high watermark.
- R9: The ret_lb_i and ret_dir_i inputs give the number of credits returned to each pool in a cycle. That number is added to the pool at the clock edge ending the cycle.
- R10: The pool count, plus all port balances, plus the credits accepted and not yet returned, always equals the pool size.
- R11: A start pulse while the block is running has no effect. Credits returned before the first start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Arms the block and pre-charges the ports (first pulse only) |
| enq_valid_i | input | NUM_PORTS | Enqueue request, one bit per port |
| enq_dir_i | input | NUM_PORTS | Credit kind per request: 0 load-balanced, 1 directed |
| ret_lb_i | input | RW | Load-balanced credits returned this cycle |
| ret_dir_i | input | RW | Directed credits returned this cycle |
| enq_ok_o | output | NUM_PORTS | Request accepted |
| enq_fail_o | output | NUM_PORTS | Request refused for lack of credit |
| lb_pool_o | output | CNT_W | Load-balanced pool count |
| dir_pool_o | output | CNT_W | Directed pool count |
| lb_cnt_o | output | NUM_PORTS*CNT_W | Load-balanced balance per port, port 0 in the low bits |
| dir_cnt_o | output | NUM_PORTS*CNT_W | Directed balance per port, port 0 in the low bits |

## Verification
A corrupted balance or pool count shows at the count outputs on the very next cycle. The accounting identity with outstanding credits then breaks in that same cycle, so a lost or duplicated credit cannot hide. A wrong refill choice shows as a port topped up out of turn, visible one edge after the round-robin pointer should have reached it. A faulty accept decision appears combinationally on the accept and refuse bits in the cycle of the request.

// File: rtl/cpm_pkg.sv
// Shared types and constant helpers for the port credit pool manager.
// Assumes: used only for elaboration-time arithmetic and pool tagging.
package cpm_pkg;

    typedef enum logic {
        POOL_LB  = 1'b0,
        POOL_DIR = 1'b1
    } pool_kind_e;

    function automatic int unsigned cpm_min(int unsigned a, int unsigned b);
        return (a < b) ? a : b;
    endfunction

    function automatic int unsigned cpm_max(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cpm_rr_arb.sv
// Round-robin single grant among N requesters.
// Assumes: a grant is consumed in the cycle it is given; the pointer then
// moves to the requester after the winner. Port 0 has first turn after reset.
module cpm_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] win_idx;
    logic [IW-1:0] scan_idx;
    logic          found;

    // Scan from the pointer and pick the first requester.
    always_comb begin
        grant_o  = '0;
        found    = 1'b0;
        win_idx  = '0;
        scan_idx = '0;
        for (int i = 0; i < N; i++) begin
            scan_idx = IW'((int'(ptr_q) + i) % N);
            if (!found && req_i[scan_idx]) begin
                found             = 1'b1;
                grant_o[scan_idx] = 1'b1;
                win_idx           = scan_idx;
            end
        end
    end

    // Advance the pointer past the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (found) begin
            ptr_q <= (win_idx == LAST) ? '0 : win_idx + IW'(1);
        end
    end

endmodule

// File: rtl/cpm_credit_pool.sv
// One credit pool and the per-port balances drawn from it.
// Assumes: spend_i only when the port balance is non-zero (gated upstream);
// returned credits never exceed the credits outstanding. Refills are exactly
// QUANT, granted only at or below LWM, with LWM <= QUANT <= HWM/2.
module cpm_credit_pool #(
    parameter int N         = 4,
    parameter int CNT_W     = 9,
    parameter int RW        = 3,
    parameter int POOL_SIZE = 256,
    parameter int HWM       = 32,
    parameter int QUANT     = 16,
    parameter int LWM       = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               active_i,
    input  logic [N-1:0]       spend_i,
    input  logic [RW-1:0]      ret_num_i,
    output logic [CNT_W-1:0]   pool_o,
    output logic [N*CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] SIZE_C = CNT_W'(POOL_SIZE);
    localparam logic [CNT_W-1:0] LEFT_C = CNT_W'(POOL_SIZE - N * HWM);
    localparam logic [CNT_W-1:0] HWM_C  = CNT_W'(HWM);
    localparam logic [CNT_W-1:0] Q_C    = CNT_W'(QUANT);
    localparam logic [CNT_W-1:0] LWM_C  = CNT_W'(LWM);

    logic [CNT_W-1:0] pool_q;
    logic [CNT_W-1:0] cnt_q [N];
    logic [N-1:0]     need;
    logic [N-1:0]     grant;

    // Per-port refill request and flattened balance output.
    for (genvar p = 0; p < N; p++) begin : g_port
        assign need[p] = active_i && (cnt_q[p] <= LWM_C) && (pool_q >= Q_C);
        assign cnt_o[p*CNT_W +: CNT_W] = cnt_q[p];
    end

    cpm_rr_arb #(.N(N)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (need),
        .grant_o (grant)
    );

    // Port balances: pre-charge on load, then spend and refill.
    always_ff @(posedge clk) begin
        for (int p = 0; p < N; p++) begin
            if (!rst_n) begin
                cnt_q[p] <= '0;
            end else if (load_i) begin
                cnt_q[p] <= HWM_C;
            end else if (active_i) begin
                cnt_q[p] <= cnt_q[p] - CNT_W'(spend_i[p]) + (grant[p] ? Q_C : '0);
            end
        end
    end

    // Pool count: fund the pre-charge, pay refills, absorb returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pool_q <= SIZE_C;
        end else if (load_i) begin
            pool_q <= LEFT_C;
        end else if (active_i) begin
            pool_q <= pool_q - ((|grant) ? Q_C : '0) + CNT_W'(ret_num_i);
        end
    end

    assign pool_o = pool_q;

endmodule

// File: rtl/cpm_enq_gate.sv
// Combinational accept/refuse decision for every port's enqueue request.
// Assumes: balances are the registered values of the current cycle.
module cpm_enq_gate #(
    parameter int N     = 4,
    parameter int CNT_W = 9
) (
    input  logic               active_i,
    input  logic [N-1:0]       valid_i,
    input  logic [N-1:0]       dir_i,
    input  logic [N*CNT_W-1:0] lb_cnt_i,
    input  logic [N*CNT_W-1:0] dir_cnt_i,
    output logic [N-1:0]       ok_o,
    output logic [N-1:0]       fail_o,
    output logic [N-1:0]       lb_spend_o,
    output logic [N-1:0]       dir_spend_o
);
    // Decide per port from the balance of the requested kind.
    for (genvar p = 0; p < N; p++) begin : g_gate
        logic has_credit;
        assign has_credit = dir_i[p] ? (dir_cnt_i[p*CNT_W +: CNT_W] != '0)
                                     : (lb_cnt_i[p*CNT_W +: CNT_W] != '0);
        assign ok_o[p]        = valid_i[p] && active_i && has_credit;
        assign fail_o[p]      = valid_i[p] && !ok_o[p];
        assign lb_spend_o[p]  = ok_o[p] && !dir_i[p];
        assign dir_spend_o[p] = ok_o[p] && dir_i[p];
    end

endmodule

// File: rtl/credit_pool_mgr.sv
// Port credit pool manager: two pools (load-balanced, directed) with per-port
// balances, watermark refills and immediate refusal on zero credit.
// Assumes: the caller never returns more credits than it was granted, and
// NUM_PORTS * high watermark fits in each pool.
module credit_pool_mgr
    import cpm_pkg::*;
#(
    parameter int NUM_PORTS         = 4,
    parameter int EVENT_LIMIT       = 256,
    parameter int ENQ_DEPTH         = 32,
    parameter int DIR_POOL_OVERRIDE = 0,
    localparam int DIR_POOL = (DIR_POOL_OVERRIDE != 0) ? DIR_POOL_OVERRIDE : EVENT_LIMIT / 4,
    localparam int CNT_W    = $clog2(cpm_max(EVENT_LIMIT, DIR_POOL) + 1),
    localparam int RW       = $clog2(NUM_PORTS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [NUM_PORTS-1:0]       enq_valid_i,
    input  logic [NUM_PORTS-1:0]       enq_dir_i,
    input  logic [RW-1:0]              ret_lb_i,
    input  logic [RW-1:0]              ret_dir_i,
    output logic [NUM_PORTS-1:0]       enq_ok_o,
    output logic [NUM_PORTS-1:0]       enq_fail_o,
    output logic [CNT_W-1:0]           lb_pool_o,
    output logic [CNT_W-1:0]           dir_pool_o,
    output logic [NUM_PORTS*CNT_W-1:0] lb_cnt_o,
    output logic [NUM_PORTS*CNT_W-1:0] dir_cnt_o
);
    localparam int LB_POOL  = EVENT_LIMIT;
    localparam int LB_HWM   = ENQ_DEPTH;
    localparam int DIR_HWM  = cpm_min(ENQ_DEPTH, DIR_POOL / NUM_PORTS);

    logic                       active_q;
    logic                       load;
    logic [NUM_PORTS-1:0]       spend [2];
    logic [RW-1:0]              ret   [2];
    logic [CNT_W-1:0]           pool_cnt [2];
    logic [NUM_PORTS*CNT_W-1:0] port_cnt [2];

    // Armed by the first start pulse; later pulses are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else if (start_i) begin
            active_q <= 1'b1;
        end
    end

    assign load = start_i && !active_q;
    assign ret[POOL_LB]  = ret_lb_i;
    assign ret[POOL_DIR] = ret_dir_i;

    cpm_enq_gate #(.N(NUM_PORTS), .CNT_W(CNT_W)) u_gate (
        .active_i    (active_q),
        .valid_i     (enq_valid_i),
        .dir_i       (enq_dir_i),
        .lb_cnt_i    (port_cnt[POOL_LB]),
        .dir_cnt_i   (port_cnt[POOL_DIR]),
        .ok_o        (enq_ok_o),
        .fail_o      (enq_fail_o),
        .lb_spend_o  (spend[POOL_LB]),
        .dir_spend_o (spend[POOL_DIR])
    );

    // One pool instance per credit kind, parameters picked by kind.
    for (genvar k = 0; k < 2; k++) begin : g_pool
        localparam int PSIZE = (k == 0) ? LB_POOL : DIR_POOL;
        localparam int PHWM  = (k == 0) ? LB_HWM : DIR_HWM;
        localparam int PQ    = PHWM / 2;
        localparam int PLWM  = cpm_min(16, PQ);

        cpm_credit_pool #(
            .N(NUM_PORTS), .CNT_W(CNT_W), .RW(RW),
            .POOL_SIZE(PSIZE), .HWM(PHWM), .QUANT(PQ), .LWM(PLWM)
        ) u_pool (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (load),
            .active_i  (active_q),
            .spend_i   (spend[k]),
            .ret_num_i (ret[k]),
            .pool_o    (pool_cnt[k]),
            .cnt_o     (port_cnt[k])
        );
    end

    assign lb_pool_o  = pool_cnt[POOL_LB];
    assign dir_pool_o = pool_cnt[POOL_DIR];
    assign lb_cnt_o   = port_cnt[POOL_LB];
    assign dir_cnt_o  = port_cnt[POOL_DIR];

endmodule

// File: rtl/cpm_checker.sv
// Property checker for credit_pool_mgr, attached with bind.
// Assumes: returns are only counted while the block is armed, matching the design.
module cpm_checker #(
    parameter int N        = 4,
    parameter int CNT_W    = 9,
    parameter int RW       = 3,
    parameter int LB_SIZE  = 256,
    parameter int DIR_SIZE = 64,
    parameter int LB_HWM   = 32,
    parameter int DIR_HWM  = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               active_q,
    input logic [N-1:0]       enq_valid_i,
    input logic [N-1:0]       enq_dir_i,
    input logic [N-1:0]       enq_ok_o,
    input logic [N-1:0]       enq_fail_o,
    input logic [RW-1:0]      ret_lb_i,
    input logic [RW-1:0]      ret_dir_i,
    input logic [CNT_W-1:0]   lb_pool_o,
    input logic [CNT_W-1:0]   dir_pool_o,
    input logic [N*CNT_W-1:0] lb_cnt_o,
    input logic [N*CNT_W-1:0] dir_cnt_o
);
    int out_lb, out_dir;
    int acc_lb, acc_dir;
    int sum_lb, sum_dir;

    // Count accepts per kind and total the visible balances.
    always_comb begin
        acc_lb  = 0;
        acc_dir = 0;
        sum_lb  = int'(lb_pool_o);
        sum_dir = int'(dir_pool_o);
        for (int p = 0; p < N; p++) begin
            if (enq_ok_o[p] && !enq_dir_i[p]) acc_lb++;
            if (enq_ok_o[p] && enq_dir_i[p])  acc_dir++;
            sum_lb  += int'(lb_cnt_o[p*CNT_W +: CNT_W]);
            sum_dir += int'(dir_cnt_o[p*CNT_W +: CNT_W]);
        end
    end

    // Credits granted to the caller and not yet returned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_lb  <= 0;
            out_dir <= 0;
        end else if (active_q) begin
            out_lb  <= out_lb + acc_lb - int'(ret_lb_i);
            out_dir <= out_dir + acc_dir - int'(ret_dir_i);
        end
    end

    // R10: conservation across pool, ports and outstanding credits.
    a_r10_lb_conserved: assert property (@(posedge clk) disable iff (!rst_n)
        sum_lb + out_lb == LB_SIZE);
    a_r10_dir_conserved: assert property (@(posedge clk) disable iff (!rst_n)
        sum_dir + out_dir == DIR_SIZE);

    for (genvar p = 0; p < N; p++) begin : g_chk
        // R5: an accept needs a non-zero balance of the requested kind.
        a_r5_ok_has_credit: assert property (@(posedge clk) disable iff (!rst_n)
            enq_ok_o[p] |-> (enq_dir_i[p] ? (dir_cnt_o[p*CNT_W +: CNT_W] != '0)
                                          : (lb_cnt_o[p*CNT_W +: CNT_W] != '0)));
        // R5: exactly one answer per request, none without one.
        a_r5_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
            enq_valid_i[p] |-> $countones({enq_ok_o[p], enq_fail_o[p]}) == 1);
        a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
            !enq_valid_i[p] |-> !(enq_ok_o[p] || enq_fail_o[p]));
        // R8: balances stay at or below their high watermarks.
        a_r8_lb_cap: assert property (@(posedge clk) disable iff (!rst_n)
            lb_cnt_o[p*CNT_W +: CNT_W] <= CNT_W'(LB_HWM));
        a_r8_dir_cap: assert property (@(posedge clk) disable iff (!rst_n)
            dir_cnt_o[p*CNT_W +: CNT_W] <= CNT_W'(DIR_HWM));
    end

    // R11: once armed, the block stays armed.
    a_r11_stays_armed: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |=> active_q);

endmodule

bind credit_pool_mgr cpm_checker #(
    .N(NUM_PORTS), .CNT_W(CNT_W), .RW(RW),
    .LB_SIZE(LB_POOL), .DIR_SIZE(DIR_POOL),
    .LB_HWM(LB_HWM), .DIR_HWM(DIR_HWM)
) u_cpm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_q    (active_q),
    .enq_valid_i (enq_valid_i),
    .enq_dir_i   (enq_dir_i),
    .enq_ok_o    (enq_ok_o),
    .enq_fail_o  (enq_fail_o),
    .ret_lb_i    (ret_lb_i),
    .ret_dir_i   (ret_dir_i),
    .lb_pool_o   (lb_pool_o),
    .dir_pool_o  (dir_pool_o),
    .lb_cnt_o    (lb_cnt_o),
    .dir_cnt_o   (dir_cnt_o)
);

// File: tb/credit_pool_mgr_test.sv
// Bench for credit_pool_mgr with default parameters: 4 ports, limit 256, depth 32.
// Expected values come from a cycle model built from the requirements.
module credit_pool_mgr_test;
    localparam int NP = 4;
    localparam int CW = 9;
    localparam int RWB = 3;
    localparam int LB_SIZE = 256, DIR_SIZE = 64;
    localparam int LB_HWM = 32, LB_Q = 16, LB_LWM = 16;
    localparam int DIR_HWM = 16, DIR_Q = 8, DIR_LWM = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [NP-1:0] enq_valid_i = '0, enq_dir_i = '0;
    logic [RWB-1:0] ret_lb_i = '0, ret_dir_i = '0;
    logic [NP-1:0] enq_ok_o, enq_fail_o;
    logic [CW-1:0] lb_pool_o, dir_pool_o;
    logic [NP*CW-1:0] lb_cnt_o, dir_cnt_o;

    always #4 clk = ~clk;

    credit_pool_mgr uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .enq_valid_i(enq_valid_i), .enq_dir_i(enq_dir_i),
        .ret_lb_i(ret_lb_i), .ret_dir_i(ret_dir_i),
        .enq_ok_o(enq_ok_o), .enq_fail_o(enq_fail_o),
        .lb_pool_o(lb_pool_o), .dir_pool_o(dir_pool_o),
        .lb_cnt_o(lb_cnt_o), .dir_cnt_o(dir_cnt_o)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // Model state
    int m_lbp, m_dirp, m_act, m_plb, m_pdir, out_lb, out_dir;
    int m_lb [NP];
    int m_dir [NP];

    typedef struct packed {
        logic [3:0] v;
        logic [3:0] d;
        logic [2:0] rl;
        logic [2:0] rd;
        logic [7:0] reps;
    } vec_t;

    // Stimulus vectors: requests, kinds, returns, repeat count.
    localparam vec_t VECS [12] = '{
        '{4'b1111, 4'b0000, 3'd0, 3'd0, 8'd6},
        '{4'b1111, 4'b1111, 3'd2, 3'd0, 8'd5},
        '{4'b0101, 4'b0100, 3'd4, 3'd3, 8'd9},
        '{4'b1010, 4'b1010, 3'd1, 3'd4, 8'd7},
        '{4'b0000, 4'b0000, 3'd4, 3'd4, 8'd10},
        '{4'b1111, 4'b0011, 3'd3, 3'd2, 8'd20},
        '{4'b1000, 4'b0000, 3'd0, 3'd0, 8'd30},
        '{4'b0111, 4'b0111, 3'd0, 3'd1, 8'd12},
        '{4'b1111, 4'b1111, 3'd4, 3'd4, 8'd25},
        '{4'b0000, 4'b0000, 3'd7, 3'd7, 8'd20},
        '{4'b1111, 4'b1010, 3'd2, 3'd1, 8'd15},
        '{4'b0000, 4'b0000, 3'd4, 3'd4, 8'd30}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lbc(int p);
        return int'(lb_cnt_o[p*CW +: CW]);
    endfunction
    function automatic int dirc(int p);
        return int'(dir_cnt_o[p*CW +: CW]);
    endfunction

    task automatic model_reset();
        m_lbp = LB_SIZE; m_dirp = DIR_SIZE; m_act = 0;
        m_plb = 0; m_pdir = 0; out_lb = 0; out_dir = 0;
        for (int p = 0; p < NP; p++) begin m_lb[p] = 0; m_dir[p] = 0; end
    endtask

    // One clock cycle: drive, compare against the model, advance the model.
    task automatic step(input logic [3:0] v, input logic [3:0] d,
                        input int rl, input int rd, input logic st);
        logic [3:0] eok;
        int g_lb, g_dir, s_lb, s_dir, tot_lb, tot_dir;
        @(negedge clk);
        enq_valid_i = v; enq_dir_i = d;
        ret_lb_i = RWB'(rl); ret_dir_i = RWB'(rd); start_i = st;
        #1;
        eok = '0;
        for (int p = 0; p < NP; p++)
            eok[p] = v[p] && m_act != 0 && (d[p] ? m_dir[p] > 0 : m_lb[p] > 0);
        chk("R5 accept mask", int'(enq_ok_o), int'(eok));
        chk("R5 refuse mask", int'(enq_fail_o), int'(v & ~eok));
        chk("R9 lb pool", int'(lb_pool_o), m_lbp);
        chk("R9 dir pool", int'(dir_pool_o), m_dirp);
        tot_lb = int'(lb_pool_o) + out_lb;
        tot_dir = int'(dir_pool_o) + out_dir;
        for (int p = 0; p < NP; p++) begin
            chk("R4 lb balance", lbc(p), m_lb[p]);
            chk("R4 dir balance", dirc(p), m_dir[p]);
            chk("R8 lb cap", int'(lbc(p) <= LB_HWM), 1);
            chk("R8 dir cap", int'(dirc(p) <= DIR_HWM), 1);
            tot_lb += lbc(p);
            tot_dir += dirc(p);
        end
        chk("R10 lb conservation", tot_lb, LB_SIZE);
        chk("R10 dir conservation", tot_dir, DIR_SIZE);
        // Next model state
        if (st && m_act == 0) begin
            m_act = 1;
            m_lbp = LB_SIZE - NP * LB_HWM;
            m_dirp = DIR_SIZE - NP * DIR_HWM;
            for (int p = 0; p < NP; p++) begin m_lb[p] = LB_HWM; m_dir[p] = DIR_HWM; end
        end else if (m_act != 0) begin
            g_lb = -1; g_dir = -1;
            for (int i = 0; i < NP; i++) begin
                int q;
                q = (m_plb + i) % NP;
                if (g_lb < 0 && m_lb[q] <= LB_LWM && m_lbp >= LB_Q) g_lb = q;
                q = (m_pdir + i) % NP;
                if (g_dir < 0 && m_dir[q] <= DIR_LWM && m_dirp >= DIR_Q) g_dir = q;
            end
            s_lb = 0; s_dir = 0;
            for (int p = 0; p < NP; p++) begin
                if (eok[p] && !d[p]) begin m_lb[p]--; s_lb++; end
                if (eok[p] && d[p]) begin m_dir[p]--; s_dir++; end
            end
            if (g_lb >= 0) begin m_lb[g_lb] += LB_Q; m_lbp -= LB_Q; m_plb = (g_lb + 1) % NP; end
            if (g_dir >= 0) begin m_dir[g_dir] += DIR_Q; m_dirp -= DIR_Q; m_pdir = (g_dir + 1) % NP; end
            m_lbp += rl; m_dirp += rd;
            out_lb += s_lb - rl; out_dir += s_dir - rd;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(4'b0000, 4'b0000, 0, 0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start_i = 1'b0; enq_valid_i = '0; ret_lb_i = '0; ret_dir_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int rl, rd;
        do_reset();
        // R1: reset state and refusal before start
        #1;
        chk("R1 lb pool after reset", int'(lb_pool_o), 256);
        chk("R1 dir pool after reset", int'(dir_pool_o), 64);
        chk("R1 port balances after reset", int'(lb_cnt_o | dir_cnt_o), 0);
        step(4'b1111, 4'b0101, 0, 0, 1'b0);
        // R11: returns before start ignored
        step(4'b0000, 4'b0000, 3, 2, 1'b0);
        chk("R11 lb pool ignores early return", int'(lb_pool_o), 256);
        chk("R11 dir pool ignores early return", int'(dir_pool_o), 64);
        // R2, R3: pre-charge
        step(4'b0000, 4'b0000, 0, 0, 1'b1);
        chk("R2 lb pool after start", int'(lb_pool_o), 128);
        chk("R2 dir pool after start", int'(dir_pool_o), 0);
        chk("R3 lb high watermark port 3", lbc(3), 32);
        chk("R3 dir high watermark port 2", dirc(2), 16);
        // R11: second start ignored
        step(4'b0000, 4'b0000, 0, 0, 1'b1);
        chk("R11 start while running", int'(lb_pool_o), 128);
        // R4: one load-balanced spend on port 0
        step(4'b0001, 4'b0000, 0, 0, 1'b0);
        chk("R4 lb spend port 0", lbc(0), 31);
        chk("R4 dir untouched port 0", dirc(0), 16);
        // R7: ports 1..3 reach the low watermark together
        repeat (16) step(4'b1110, 4'b0000, 0, 0, 1'b0);
        idle();
        chk("R7 first refill port 1", lbc(1), 32);
        chk("R7 port 2 waits", lbc(2), 16);
        idle();
        chk("R7 second refill port 2", lbc(2), 32);
        chk("R7 port 3 waits", lbc(3), 16);
        idle();
        chk("R7 third refill port 3", lbc(3), 32);
        chk("R6 lb pool after three quanta", int'(lb_pool_o), 80);
        // R5: drain the directed balance of port 0 (directed pool is empty)
        repeat (16) step(4'b0001, 4'b0001, 0, 0, 1'b0);
        chk("R5 dir balance drained", dirc(0), 0);
        @(negedge clk); enq_valid_i = 4'b0001; enq_dir_i = 4'b0001; #1;
        chk("R5 refuse at zero credit", int'(enq_fail_o[0]), 1);
        chk("R5 no accept at zero credit", int'(enq_ok_o[0]), 0);
        step(4'b0001, 4'b0001, 0, 0, 1'b0);
        chk("R5 refused request leaves balance", dirc(0), 0);
        // R9: returns land one edge later
        step(4'b0000, 4'b0000, 0, 4, 1'b0);
        chk("R9 dir pool after return", int'(dir_pool_o), 4);
        step(4'b0000, 4'b0000, 0, 4, 1'b0);
        chk("R9 dir pool after second return", int'(dir_pool_o), 8);
        // R6: one quantum moves to port 0
        idle();
        chk("R6 dir refill port 0", dirc(0), 8);
        chk("R6 dir pool paid quantum", int'(dir_pool_o), 0);
        // Vector table walk, returns clamped to outstanding credits
        foreach (VECS[i]) begin
            for (int r = 0; r < int'(VECS[i].reps); r++) begin
                rl = (int'(VECS[i].rl) < out_lb) ? int'(VECS[i].rl) : out_lb;
                rd = (int'(VECS[i].rd) < out_dir) ? int'(VECS[i].rd) : out_dir;
                step(VECS[i].v, VECS[i].d, rl, rd, 1'b0);
            end
        end
        // R1: reset in mid-run restores the initial state
        do_reset();
        #1;
        chk("R1 lb pool after second reset", int'(lb_pool_o), 256);
        chk("R1 balances after second reset", int'(lb_cnt_o | dir_cnt_o), 0);
        step(4'b0011, 4'b0000, 0, 0, 1'b0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule